// File: doc/BRIEF.md
# Alarm-Started Interval Pulse Generator

This block drives two periodic pulse trains whose spacing is programmed in nanoseconds. It sits beside a nanosecond time counter. On every counter increment strobe it also sees the number of nanoseconds that strobe adds. Each train counts that time down and emits a single-cycle pulse when its interval has elapsed. Remainders carry over, so a train keeps phase with the counter even when the interval is not a whole multiple of the increment.

Each programmed interval is written as the wanted period minus one counter increment. When alarm-start is enabled, both trains stay idle until the time counter's alarm event. Software sets that alarm one increment before a whole second, so the first pulse lands on the second boundary. A re-arm input returns both trains to idle. Software uses it when it writes or steps the counter, then reloads the intervals and waits for the new alarm. The pulses of the first train also drive an event flag for the interrupt logic.

Top module: `ivl_pulse_top`

## Requirements
- R1: While reset is asserted and on the cycle after it is released, `pulse0`, `pulse1` and `pulse_evt` are low and both trains are idle.
- R2: With `start_en`=1, an idle train emits no pulse until `alarm` is high on a clock edge. At that edge it becomes running, loads its interval value, and its pulse is high for the following cycle.
- R3: A running train does this on each edge where `tick` is high. If its count is below `inc_ns`, it adds its interval value to the count and pulses. Otherwise it subtracts `inc_ns`. With P = interval + `inc_ns`, the j-th tick after the start pulses exactly when floor(((j+1)*inc-1)/P) differs from floor((j*inc-1)/P).
- R4: Each pulse is registered. It is high for the one cycle after the edge that caused it, and it is never high unless that edge had a start or a tick.
- R5: `alarm` has no effect on a train that is already running. Its pulse pattern is unchanged.
- R6: `rearm` high on an edge sends both trains to idle and suppresses any pulse from that edge. It takes priority over `alarm` and `tick`. Afterwards the trains wait for a new start.
- R7: With `start_en`=0, an idle train starts on the next edge where `rearm` is low, without waiting for `alarm`. It pulses as in R2.
- R8: `pulse_evt` is high exactly in the cycles where `pulse0` is high, and it ignores the second train.
- R9: The two trains use their own interval inputs and keep independent phase.
- R10: A new interval value is used at the next start or underflow reload. A count that is already loaded is left as it is.
- R11: On edges where `tick` is low, a running train keeps its count and does not pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rearm | input | 1 | Return both trains to idle |
| start_en | input | 1 | 1: start on alarm; 0: start at once |
| tick | input | 1 | Time counter increment strobe |
| inc_ns | input | INC_W | Nanoseconds added per strobe |
| alarm | input | 1 | Alarm event from the time counter |
| interval0 | input | IVL_W | Train 0 period minus one increment |
| interval1 | input | IVL_W | Train 1 period minus one increment |
| pulse0 | output | 1 | Train 0 pulse |
| pulse1 | output | 1 | Train 1 pulse |
| pulse_evt | output | 1 | Pulse event flag from train 0 |

## Verification
Several rules are checked by assertions on every cycle. An idle train without a start stays silent. Re-arm forces idle with no pulse. A running train without a tick holds its count, whatever `alarm` does. Every pulse has a start or tick behind it. The event flag follows train 0. Only the bench scenarios can show the pulse spacing, the carried remainder, the alarm-start alignment and the delayed take-up of a changed interval. The bench compares every cycle of a sweep over increment sizes, interval values and strobe densities with the closed-form pulse schedule.

// File: rtl/ivl_pulse_pkg.sv
package ivl_pulse_pkg;
  typedef enum logic {
    LANE_IDLE = 1'b0,
    LANE_RUN  = 1'b1
  } lane_state_e;
endpackage

// File: rtl/ivl_pulse_lane.sv
module ivl_pulse_lane
  import ivl_pulse_pkg::*;
#(
  parameter int IVL_W = 32,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rearm_i,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic [IVL_W-1:0] ivl_i,
  output logic             fire_o,
  output logic             pulse_o
);
  localparam int PAD_W = IVL_W - INC_W;

  lane_state_e      st_q;
  logic [IVL_W-1:0] cnt_q;
  logic [IVL_W-1:0] inc_ext;
  logic             start_w;
  logic             run_tick_w;
  logic             under_w;

  function automatic logic is_under(input logic [IVL_W-1:0] c, input logic [IVL_W-1:0] s);
    return c < s;
  endfunction

  function automatic logic [IVL_W-1:0] next_count(input logic [IVL_W-1:0] c,
                                                  input logic [IVL_W-1:0] s,
                                                  input logic [IVL_W-1:0] ivl,
                                                  input logic             u);
    return u ? (c + ivl) : (c - s);
  endfunction

  assign inc_ext    = {{PAD_W{1'b0}}, inc_i};
  assign start_w    = (st_q == LANE_IDLE) && start_i && !rearm_i;
  assign run_tick_w = (st_q == LANE_RUN) && tick_i && !rearm_i;
  assign under_w    = is_under(cnt_q, inc_ext);
  assign fire_o     = start_w || (run_tick_w && under_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= LANE_IDLE;
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= fire_o;
      if (rearm_i) begin
        st_q <= LANE_IDLE;
      end else if (start_w) begin
        st_q  <= LANE_RUN;
        cnt_q <= ivl_i;
      end else if (run_tick_w) begin
        cnt_q <= next_count(cnt_q, inc_ext, ivl_i, under_w);
      end
    end
  end

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LANE_IDLE && !start_i) |=> !pulse_o); // R2
  AST_REARM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i |=> (st_q == LANE_IDLE && !pulse_o)); // R6
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LANE_RUN && !tick_i && !rearm_i) |=> ($stable(cnt_q) && !pulse_o)); // R11
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LANE_RUN && !rearm_i) |=> st_q == LANE_RUN); // R5
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> $past(start_i || tick_i)); // R4
endmodule

// File: rtl/ivl_pulse_top.sv
module ivl_pulse_top #(
  parameter int IVL_W = 32,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rearm,
  input  logic             start_en,
  input  logic             tick,
  input  logic [INC_W-1:0] inc_ns,
  input  logic             alarm,
  input  logic [IVL_W-1:0] interval0,
  input  logic [IVL_W-1:0] interval1,
  output logic             pulse0,
  output logic             pulse1,
  output logic             pulse_evt
);
  localparam int N_LANE = 2;

  logic [IVL_W-1:0] ivl_w [N_LANE];
  logic [N_LANE-1:0] fire_w;
  logic [N_LANE-1:0] pulse_w;
  logic              start_w;
  logic              evt_q;

  assign ivl_w[0] = interval0;
  assign ivl_w[1] = interval1;
  assign start_w  = alarm || !start_en;

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    ivl_pulse_lane #(.IVL_W(IVL_W), .INC_W(INC_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .rearm_i (rearm),
      .start_i (start_w),
      .tick_i  (tick),
      .inc_i   (inc_ns),
      .ivl_i   (ivl_w[g]),
      .fire_o  (fire_w[g]),
      .pulse_o (pulse_w[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= fire_w[0];
  end

  assign pulse0    = pulse_w[0];
  assign pulse1    = pulse_w[1];
  assign pulse_evt = evt_q;

  AST_EVT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_evt == pulse0); // R8
  AST_REARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> (!pulse0 && !pulse1 && !pulse_evt)); // R6
endmodule

// File: tb/sim_ivl_pulse_top.sv
module sim_ivl_pulse_top;
  localparam int CLK_PERIOD = 10;
  localparam int IVL_W = 32;
  localparam int INC_W = 8;

  logic clk = 1'b0;
  logic rst_n, rearm, start_en, tick, alarm;
  logic [INC_W-1:0] inc_ns;
  logic [IVL_W-1:0] interval0, interval1;
  logic pulse0, pulse1, pulse_evt;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivl_pulse_top #(.IVL_W(IVL_W), .INC_W(INC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .rearm(rearm), .start_en(start_en), .tick(tick),
    .inc_ns(inc_ns), .alarm(alarm), .interval0(interval0), .interval1(interval1),
    .pulse0(pulse0), .pulse1(pulse1), .pulse_evt(pulse_evt)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // closed-form schedule: does the j-th tick after start produce a pulse
  function automatic bit sched(input int j, input int inc, input int per);
    return (((j + 1) * inc - 1) / per) != ((j * inc - 1) / per);
  endfunction

  task automatic run_case(input int inc, input int s0, input int s1, input int every);
    int j = 0;
    int bad0 = 0, bad1 = 0, bade = 0;
    int a0 = 0, e0 = 0, a1 = 0, e1 = 0;
    inc_ns = INC_W'(inc); interval0 = IVL_W'(s0); interval1 = IVL_W'(s1);
    start_en = 1'b1; rearm = 1'b1; alarm = 1'b0; tick = 1'b0;
    step();
    rearm = 1'b0; alarm = 1'b1; tick = 1'b1;
    step();
    if (pulse0 != 1'b1) bad0++;
    if (pulse1 != 1'b1) bad1++;
    if (pulse_evt != 1'b1) bade++;
    alarm = 1'b0;
    for (int c = 1; c <= 40; c++) begin
      bit tk = (c % every) == 0;
      bit x0, x1;
      tick = tk;
      alarm = tk && (j + 1 == 2);   // R5: alarm while running
      step();
      if (tk) j++;
      x0 = tk && sched(j, inc, s0 + inc);
      x1 = tk && sched(j, inc, s1 + inc);
      if (pulse0 != x0) begin bad0++; a0 = pulse0; e0 = x0; end
      if (pulse1 != x1) begin bad1++; a1 = pulse1; e1 = x1; end
      if (pulse_evt != x0) bade++;
    end
    tick = 1'b0; alarm = 1'b0;
    check($sformatf("R3 R5 R11 lane0 inc=%0d s=%0d bad=%0d pulse", inc, s0, bad0), a0 + bad0, e0);
    check($sformatf("R4 R9 lane1 inc=%0d s=%0d bad=%0d pulse", inc, s1, bad1), a1 + bad1, e1);
    check($sformatf("R8 evt inc=%0d mismatches", inc), bade, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cnt;
    rst_n = 1'b0; rearm = 1'b0; start_en = 1'b1; tick = 1'b0; alarm = 1'b0;
    inc_ns = 8'd1; interval0 = 32'd3; interval1 = 32'd5;
    repeat (3) step();
    check("R1 pulse0 in reset", pulse0, 0);
    check("R1 pulse_evt in reset", pulse_evt, 0);
    rst_n = 1'b1; tick = 1'b1;
    step();
    check("R1 pulse1 after reset", pulse1, 0);
    cnt = 0;
    for (int k = 0; k < 8; k++) begin step(); cnt += pulse0 + pulse1; end
    check("R2 idle without alarm pulse count", cnt, 0);

    // R2 R3 R9 sweep
    for (int inc = 1; inc <= 4; inc++)
      for (int s0 = 0; s0 <= 6; s0++)
        for (int ev = 1; ev <= 2; ev++)
          run_case(inc, s0, (s0 * 3 + 1) % 9, ev);

    // R6: rearm then no alarm -> silent
    rearm = 1'b1; tick = 1'b1; alarm = 1'b1;
    step();
    check("R6 rearm suppresses pulse0", pulse0, 0);
    rearm = 1'b0; alarm = 1'b0; cnt = 0;
    for (int k = 0; k < 12; k++) begin step(); cnt += pulse0 + pulse1 + pulse_evt; end
    check("R6 idle after rearm pulse count", cnt, 0);

    // R7: start_en=0 starts without alarm
    start_en = 1'b0; rearm = 1'b1; tick = 1'b0;
    step();
    rearm = 1'b0;
    step();
    check("R7 pulse0 on free start", pulse0, 1);
    check("R7 pulse1 on free start", pulse1, 1);

    // R10: interval change after load
    start_en = 1'b1; inc_ns = 8'd1; interval0 = 32'd3; rearm = 1'b1;
    step();
    rearm = 1'b0; alarm = 1'b1;
    step();
    alarm = 1'b0; interval0 = 32'd1; tick = 1'b1; cnt = 0;
    for (int k = 1; k <= 6; k++) begin
      step();
      cnt = cnt * 2 + pulse0;
    end
    check("R10 pattern ticks1-6 (binary)", cnt, 6'b000101);
    tick = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule